// File: doc/BRIEF.md
# PAL-style composite sync and test-bar generator

The block produces a simplified, progressive PAL-style frame on two digital pins. One pin carries sync and the other carries video, and an external resistor network sums them into composite video. Sync low is the 0 V sync tip and sync high is the 0.3 V black level. Video raises the level toward white, and the block only drives video while sync is high. The timing assumes a 24 MHz clock, so every duration below is a count of clocks.

Each frame opens with a group of long vertical sync pulses. A group of short pulses follows, then a run of picture lines. Each picture line carries a horizontal sync pulse, a back porch and an active region filled with a fixed three-band test pattern. A trailing group of short pulses closes the frame, and the sequence then starts again. Two one-clock strobes mark the start of each frame and the start of each picture line. An active-high enable freezes the whole sequence in place.

Top module: `pal_sync_gen`

## Requirements
- R1: While `rst_i` is high at a clock edge, all four outputs are low after that edge. After reset is released, the first enabled edge starts the frame at the first clock of the first long pulse.
- R2: A frame begins with N_LONG (default 5) long pulses. In each long pulse, sync is low for 720 clocks and then high for 48 clocks.
- R3: The long pulses are followed by N_SHORT_A (default 5) short pulses. In each short pulse, sync is low for 48 clocks and then high for 720 clocks.
- R4: After the short pulses come N_LINES (default 304) picture lines of 1536 clocks each. In each line, sync is low for 96 clocks and then high for 1440 clocks.
- R5: Video is low during the sync-low part of every pulse and line, and during the 192-clock back porch that follows horizontal sync. Video is never high while sync is low.
- R6: The active region starts 288 clocks into a line and lasts 1248 clocks. Take the offset a into the active region. For a in 0..415, video is high when (a mod 6) < 3, so the stripe starts high and runs 3 clocks high, 3 clocks low.
- R7: For a in 416..831, video is low. For a in 832..1247, video is high. Video is low again when the next line's sync begins.
- R8: After the lines, N_SHORT_B (default 6) short pulses of the R3 shape are sent. The next frame then starts with a long pulse.
- R9: `frame_start_o` is high for exactly one clock, in the same cycle as the first sync-low clock of the first long pulse. It is low at all other times.
- R10: `line_start_o` is high for exactly one clock, in the same cycle as the first sync-low clock of each picture line. It is low at all other times.
- R11: While `en_i` is low, `sync_o` and `video_o` hold their values and both strobes are low. When `en_i` rises again, the sequence resumes from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 24 MHz clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance enable, active high |
| sync_o | output | 1 | Sync level: 0 = sync tip, 1 = black level |
| video_o | output | 1 | Video level: 1 = white |
| frame_start_o | output | 1 | One-clock strobe at the start of a frame |
| line_start_o | output | 1 | One-clock strobe at the start of each picture line |

## Verification
The hardest case to reach from the ports is the seam at the end of a frame: the last trailing short pulse wraps into the first long pulse. With default timing, a frame lasts close to half a million clocks. The bench therefore overrides the line count to 4, which keeps every pulse and line duration unchanged and lets two full frames and both seams run in about 37 thousand clocks. A mid-line enable pause and a mid-frame reset then check that the sequence holds its position, and that it restarts at the first long pulse.

// File: rtl/pal_pkg.sv
package pal_pkg;

  typedef enum logic [1:0] {
    PH_LONG    = 2'd0,
    PH_SHORT_A = 2'd1,
    PH_LINES   = 2'd2,
    PH_SHORT_B = 2'd3
  } phase_t;

  // Order of the groups inside one frame.
  function automatic phase_t phase_after(phase_t p);
    case (p)
      PH_LONG:    return PH_SHORT_A;
      PH_SHORT_A: return PH_LINES;
      PH_LINES:   return PH_SHORT_B;
      default:    return PH_LONG;
    endcase
  endfunction

  // Sync is at the tip for the first low_len clocks of a slot.
  function automatic logic pulse_sync_level(int unsigned pos, int unsigned low_len);
    return pos >= low_len;
  endfunction

  // Three-band pattern: fine stripe, dark band, bright band.
  function automatic logic stripe_band_level(int unsigned a, int unsigned active,
                                             int unsigned half);
    if (a >= active) return 1'b0;
    if (a < active / 3) return (a % (2 * half)) < half;
    if (a < (2 * active) / 3) return 1'b0;
    return 1'b1;
  endfunction

endpackage

// File: rtl/pal_slot_counter.sv
module pal_slot_counter #(
  parameter int W = 11
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         step_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] pos_o,
  output logic         wrap_o
);
  assign wrap_o = step_i && (pos_o == last_i);

  always_ff @(posedge clk_i) begin
    if (rst_i)        pos_o <= '0;
    else if (wrap_o)  pos_o <= '0;
    else if (step_i)  pos_o <= pos_o + 1'b1;
  end
endmodule

// File: rtl/pal_phase_seq.sv
module pal_phase_seq
  import pal_pkg::*;
#(
  parameter int N_LONG    = 5,
  parameter int N_SHORT_A = 5,
  parameter int N_LINES   = 304,
  parameter int N_SHORT_B = 6,
  parameter int CW        = 9
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          adv_i,
  output phase_t        phase_o,
  output logic [CW-1:0] item_o
);
  logic [CW-1:0] item_last;
  logic          group_done;

  always_comb begin
    case (phase_o)
      PH_LONG:    item_last = CW'(N_LONG - 1);
      PH_SHORT_A: item_last = CW'(N_SHORT_A - 1);
      PH_LINES:   item_last = CW'(N_LINES - 1);
      default:    item_last = CW'(N_SHORT_B - 1);
    endcase
  end

  assign group_done = adv_i && (item_o == item_last);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_o <= PH_LONG;
      item_o  <= '0;
    end else if (group_done) begin
      phase_o <= phase_after(phase_o);
      item_o  <= '0;
    end else if (adv_i) begin
      item_o  <= item_o + 1'b1;
    end
  end
endmodule

// File: rtl/pal_line_shaper.sv
module pal_line_shaper
  import pal_pkg::*;
#(
  parameter int LONG_LO     = 720,
  parameter int SHORT_LO    = 48,
  parameter int HSYNC_LEN   = 96,
  parameter int PORCH_LEN   = 192,
  parameter int ACTIVE_LEN  = 1248,
  parameter int STRIPE_HALF = 3,
  parameter int PW          = 11,
  parameter int CW          = 9
) (
  input  phase_t        phase_i,
  input  logic [PW-1:0] pos_i,
  input  logic [CW-1:0] item_i,
  output logic          sync_n_o,
  output logic          video_n_o,
  output logic          frame_start_n_o,
  output logic          line_start_n_o
);
  localparam int unsigned ACT_START = HSYNC_LEN + PORCH_LEN;

  int unsigned p;

  always_comb begin
    p               = 32'(pos_i);
    sync_n_o        = 1'b1;
    video_n_o       = 1'b0;
    frame_start_n_o = 1'b0;
    line_start_n_o  = 1'b0;
    case (phase_i)
      PH_LONG: begin
        sync_n_o        = pulse_sync_level(p, LONG_LO);
        frame_start_n_o = (item_i == '0) && (p == 0);
      end
      PH_SHORT_A, PH_SHORT_B: begin
        sync_n_o = pulse_sync_level(p, SHORT_LO);
      end
      PH_LINES: begin
        sync_n_o       = pulse_sync_level(p, HSYNC_LEN);
        line_start_n_o = (p == 0);
        if (p >= ACT_START)
          video_n_o = stripe_band_level(p - ACT_START, ACTIVE_LEN, STRIPE_HALF);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pal_sync_gen.sv
module pal_sync_gen
  import pal_pkg::*;
#(
  parameter int LONG_LO     = 720,
  parameter int LONG_HI     = 48,
  parameter int SHORT_LO    = 48,
  parameter int SHORT_HI    = 720,
  parameter int HSYNC_LEN   = 96,
  parameter int PORCH_LEN   = 192,
  parameter int ACTIVE_LEN  = 1248,
  parameter int STRIPE_HALF = 3,
  parameter int N_LONG      = 5,
  parameter int N_SHORT_A   = 5,
  parameter int N_LINES     = 304,
  parameter int N_SHORT_B   = 6
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic sync_o,
  output logic video_o,
  output logic frame_start_o,
  output logic line_start_o
);
  localparam int LONG_LEN  = LONG_LO + LONG_HI;
  localparam int SHORT_LEN = SHORT_LO + SHORT_HI;
  localparam int LINE_LEN  = HSYNC_LEN + PORCH_LEN + ACTIVE_LEN;
  localparam int PULSE_MAX = (LONG_LEN > SHORT_LEN) ? LONG_LEN : SHORT_LEN;
  localparam int MAX_LEN   = (LINE_LEN > PULSE_MAX) ? LINE_LEN : PULSE_MAX;
  localparam int PW        = $clog2(MAX_LEN);
  localparam int CNT_A     = (N_LONG > N_SHORT_A) ? N_LONG : N_SHORT_A;
  localparam int CNT_B     = (N_LINES > N_SHORT_B) ? N_LINES : N_SHORT_B;
  localparam int MAX_CNT   = (CNT_A > CNT_B) ? CNT_A : CNT_B;
  localparam int CW        = $clog2(MAX_CNT + 1);

  // Named internal events, also used by the bound checker.
  phase_t        phase_q;
  logic [CW-1:0] item_q;
  logic [PW-1:0] pos_q;
  logic [PW-1:0] period_last;
  logic          slot_wrap;
  logic          sync_n, video_n, frame_start_n, line_start_n;

  always_comb begin
    case (phase_q)
      PH_LONG:  period_last = PW'(LONG_LEN - 1);
      PH_LINES: period_last = PW'(LINE_LEN - 1);
      default:  period_last = PW'(SHORT_LEN - 1);
    endcase
  end

  pal_slot_counter #(.W(PW)) u_slot (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .step_i (en_i),
    .last_i (period_last),
    .pos_o  (pos_q),
    .wrap_o (slot_wrap)
  );

  pal_phase_seq #(
    .N_LONG    (N_LONG),
    .N_SHORT_A (N_SHORT_A),
    .N_LINES   (N_LINES),
    .N_SHORT_B (N_SHORT_B),
    .CW        (CW)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .adv_i   (slot_wrap),
    .phase_o (phase_q),
    .item_o  (item_q)
  );

  pal_line_shaper #(
    .LONG_LO     (LONG_LO),
    .SHORT_LO    (SHORT_LO),
    .HSYNC_LEN   (HSYNC_LEN),
    .PORCH_LEN   (PORCH_LEN),
    .ACTIVE_LEN  (ACTIVE_LEN),
    .STRIPE_HALF (STRIPE_HALF),
    .PW          (PW),
    .CW          (CW)
  ) u_shape (
    .phase_i         (phase_q),
    .pos_i           (pos_q),
    .item_i          (item_q),
    .sync_n_o        (sync_n),
    .video_n_o       (video_n),
    .frame_start_n_o (frame_start_n),
    .line_start_n_o  (line_start_n)
  );

  // Registered output stage.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_o        <= 1'b0;
      video_o       <= 1'b0;
      frame_start_o <= 1'b0;
      line_start_o  <= 1'b0;
    end else if (en_i) begin
      sync_o        <= sync_n;
      video_o       <= video_n && sync_n;
      frame_start_o <= frame_start_n;
      line_start_o  <= line_start_n;
    end else begin
      frame_start_o <= 1'b0;
      line_start_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/pal_sync_gen_chk.sv
module pal_sync_gen_chk #(
  parameter int PW = 11
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          en_i,
  input logic          sync_o,
  input logic          video_o,
  input logic          frame_start_o,
  input logic          line_start_o,
  input logic [PW-1:0] pos_q,
  input logic [PW-1:0] period_last
);
  p_reset_quiet_r1: assert property (@(posedge clk_i)
    rst_i |=> (!sync_o && !video_o && !frame_start_o && !line_start_o));

  p_pos_in_slot_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    pos_q <= period_last);

  p_video_needs_black_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    video_o |-> sync_o);

  p_frame_start_at_tip_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    frame_start_o |-> (!sync_o && !line_start_o));

  p_line_start_at_tip_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    line_start_o |-> (!sync_o && !video_o));

  p_hold_levels_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> ($stable(sync_o) && $stable(video_o)));

  p_quiet_strobes_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (!frame_start_o && !line_start_o));
endmodule

bind pal_sync_gen pal_sync_gen_chk #(.PW(PW)) u_chk (
  .clk_i         (clk_i),
  .rst_i         (rst_i),
  .en_i          (en_i),
  .sync_o        (sync_o),
  .video_o       (video_o),
  .frame_start_o (frame_start_o),
  .line_start_o  (line_start_o),
  .pos_q         (pos_q),
  .period_last   (period_last)
);

// File: tb/pal_sync_gen_bench.sv
`timescale 1ns/1ps
module pal_sync_gen_bench;
  localparam int LINES_T  = 4;
  localparam int TIP_L    = 720, BLK_L = 48;
  localparam int TIP_S    = 48,  BLK_S = 720;
  localparam int SLOT     = 768;
  localparam int LSLOT    = 1536;
  localparam int SPAN_A   = 5 * SLOT;
  localparam int SPAN_B   = 5 * SLOT;
  localparam int SPAN_L   = LINES_T * LSLOT;
  localparam int SPAN_C   = 6 * SLOT;
  localparam int FRAME    = SPAN_A + SPAN_B + SPAN_L + SPAN_C;

  logic clk = 1'b0, rst = 1'b1, en = 1'b1;
  logic sync_o, video_o, frame_start_o, line_start_o;

  always #10 clk = ~clk;

  pal_sync_gen #(.N_LINES(LINES_T)) u_pal_sync_gen (
    .clk_i(clk), .rst_i(rst), .en_i(en),
    .sync_o(sync_o), .video_o(video_o),
    .frame_start_o(frame_start_o), .line_start_o(line_start_o)
  );

  int  n_checks = 0, n_err = 0;
  bit  finished = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic wrap_up();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  // ---------------- reference model: {sync, video, frame_start, line_start}
  function automatic logic [3:0] ref_out(int unsigned i);
    int unsigned k, a;
    logic s, v, f, l;
    s = 1'b1; v = 1'b0; f = 1'b0; l = 1'b0;
    if (i < SPAN_A) begin
      k = i % SLOT; s = (k >= TIP_L); f = (i == 0);
    end else if (i < SPAN_A + SPAN_B) begin
      k = (i - SPAN_A) % SLOT; s = (k >= TIP_S);
    end else if (i < SPAN_A + SPAN_B + SPAN_L) begin
      k = (i - SPAN_A - SPAN_B) % LSLOT;
      s = (k >= 96); l = (k == 0);
      if (k >= 288) begin
        a = k - 288;
        if (a < 416)      v = ((a / 3) % 2) == 0;
        else if (a < 832) v = 1'b0;
        else              v = 1'b1;
      end
    end else begin
      k = (i - SPAN_A - SPAN_B - SPAN_L) % SLOT; s = (k >= TIP_S);
    end
    return {s, v, f, l};
  endfunction

  int unsigned ref_idx = 0;
  logic [3:0]  exp_vec = 4'b0;
  bit          cmp_on = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      ref_idx <= 0;
      exp_vec <= 4'b0;
    end else if (en) begin
      exp_vec <= ref_out(ref_idx);
      ref_idx <= (ref_idx + 1 == FRAME) ? 0 : ref_idx + 1;
    end else begin
      exp_vec[1:0] <= 2'b00;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      check(sync_o == exp_vec[3], "R2/R3/R4/R8", "sync level", sync_o, exp_vec[3]);
      check(video_o == exp_vec[2], "R5/R6/R7", "video level", video_o, exp_vec[2]);
      check(frame_start_o == exp_vec[1], "R9", "frame_start", frame_start_o, exp_vec[1]);
      check(line_start_o == exp_vec[0], "R10", "line_start", line_start_o, exp_vec[0]);
    end
  end

  // ---------------- scoreboard of sync run lengths
  typedef struct { logic lvl; int unsigned len; string tag; } seg_t;
  seg_t sb_q[$];

  task automatic push_seg(input logic lvl, input int unsigned len, input string tag);
    seg_t s;
    s.lvl = lvl; s.len = len; s.tag = tag;
    sb_q.push_back(s);
  endtask

  task automatic push_frame();
    for (int i = 0; i < 5; i++) begin push_seg(1'b0, TIP_L, "R2"); push_seg(1'b1, BLK_L, "R2"); end
    for (int i = 0; i < 5; i++) begin push_seg(1'b0, TIP_S, "R3"); push_seg(1'b1, BLK_S, "R3"); end
    for (int i = 0; i < LINES_T; i++) begin push_seg(1'b0, 96, "R4"); push_seg(1'b1, 1440, "R4"); end
    for (int i = 0; i < 6; i++) begin push_seg(1'b0, TIP_S, "R8"); push_seg(1'b1, BLK_S, "R8"); end
  endtask

  bit          mon_on = 1'b0, mon_done = 1'b0;
  logic        run_lvl = 1'b0;
  int unsigned run_len = 0, mon_samples = 0, line_cnt = 0, frames_seen = 0;

  always @(negedge clk) begin
    if (mon_on && !mon_done) begin
      if (run_len == 0) begin
        run_lvl = sync_o; run_len = 1;
      end else if (sync_o == run_lvl) begin
        run_len++;
      end else begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R8", "unexpected extra sync run", run_len, 0);
        end else begin
          seg_t s;
          s = sb_q.pop_front();
          check(s.lvl == run_lvl && s.len == run_len, s.tag,
                $sformatf("sync run (level %0d)", run_lvl), run_len, s.len);
        end
        run_lvl = sync_o; run_len = 1;
      end
      if (frame_start_o) begin
        if (frames_seen > 0)
          check(line_cnt == LINES_T, "R4", "lines per frame", line_cnt, LINES_T);
        frames_seen++;
        line_cnt = 0;
      end
      if (line_start_o) line_cnt++;
      mon_samples++;
      if (mon_samples == 2 * FRAME) mon_done = 1'b1;
    end
  end

  // ---------------- watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      wrap_up();
    end
  end

  // ---------------- stimulus
  initial begin
    logic held_s, held_v;
    push_frame();
    push_frame();
    repeat (3) @(posedge clk);
    cmp_on = 1'b1;
    @(negedge clk);
    check({sync_o, video_o, frame_start_o, line_start_o} == 4'b0, "R1", "outputs in reset",
          {sync_o, video_o, frame_start_o, line_start_o}, 0);
    rst = 1'b0;
    @(posedge clk);
    mon_on = 1'b1;
    @(negedge clk);
    check(frame_start_o == 1'b1 && sync_o == 1'b0, "R1", "first clock after reset is frame start",
          {frame_start_o, sync_o}, 2'b10);
    wait (mon_done);
    check(sb_q.size() == 1, "R8", "runs left after two frames", sb_q.size(), 1);
    check(frames_seen == 2, "R9", "frame strobes in two frames", frames_seen, 2);

    // Pause inside the active region of the first picture line.
    while (ref_idx != SPAN_A + SPAN_B + 300) @(negedge clk);
    held_s = sync_o; held_v = video_o;
    en = 1'b0;
    repeat (40) @(negedge clk);
    check(sync_o == held_s && video_o == held_v, "R11", "levels held while disabled",
          {sync_o, video_o}, {held_s, held_v});
    check(!frame_start_o && !line_start_o, "R11", "strobes quiet while disabled",
          {frame_start_o, line_start_o}, 0);
    en = 1'b1;
    repeat (3000) @(negedge clk);

    // Reset in the middle of a frame.
    rst = 1'b1;
    @(negedge clk);
    check({sync_o, video_o, frame_start_o, line_start_o} == 4'b0, "R1", "mid-frame reset",
          {sync_o, video_o, frame_start_o, line_start_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(frame_start_o == 1'b1, "R1", "restart at first long pulse", frame_start_o, 1);
    repeat (5000) @(negedge clk);
    finished = 1'b1;
    wrap_up();
  end
endmodule